// File: doc/BRIEF.md
# Barrel Shifter With Carry Out

This block forms the second operand of a 32-bit data-processing unit from a register value. It applies one of five moves: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate that takes the incoming carry flag in at the top. Alongside the result it produces the carry that the move pushes out, which is the last bit to leave the operand. The surrounding datapath decides whether that carry reaches the flag register.

The shift amount has two sources. One is a small immediate field. The other is a general register, of which only the low byte is used. The select input picks one of them. Both sources follow the same amount rules. Amounts of 32 and above are handled explicitly, so register-driven shifts behave predictably across the whole byte range. The result and the carry are registered, so they appear one clock after the inputs are presented.

Top module: `bshift_carry`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` and `carry_o` both become 0 at that edge.
- R2: The result and carry for the inputs sampled at a rising edge appear on `res_o` and `carry_o` right after that edge, and stay there until the next edge.
- R3: The effective amount is `imm_amt_i` (0 to 63) when `use_imm_i` is 1. Otherwise it is `reg_amt_i[7:0]` (0 to 255), and `reg_amt_i[31:8]` has no effect.
- R4: When the effective amount is 0 and `kind_i` is 0 to 3, the operand passes through unchanged and the carry out equals `carry_i`. Codes 5 to 7 are reserved and always pass the operand through with carry `carry_i`.
- R5: Code 0 is logical left. For n from 1 to 31 the result is the operand shifted left with zeros filling from below, and the carry is operand bit 32-n. n = 32 gives 0 with carry equal to bit 0. n above 32 gives 0 with carry 0.
- R6: Code 1 is logical right. For n from 1 to 31 zeros fill from the top and the carry is bit n-1. n = 32 gives 0 with carry equal to bit 31. n above 32 gives 0 with carry 0.
- R7: Code 2 is arithmetic right. For n from 1 to 31 copies of bit 31 fill from the top and the carry is bit n-1. Any n of 32 or more gives every bit equal to bit 31, with carry equal to bit 31.
- R8: Code 3 is rotate right by n modulo 32. Bits leaving the bottom enter at the top, and the carry is result bit 31. A nonzero multiple of 32 leaves the operand unchanged with carry equal to its bit 31.
- R9: Code 4 is the one-bit extended rotate. The result is `{carry_i, operand[31:1]}` and the carry is operand bit 0, whatever the amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 extended rotate |
| use_imm_i | input | 1 | 1 selects the immediate amount, 0 the register amount |
| imm_amt_i | input | 6 | Immediate shift amount |
| reg_amt_i | input | 32 | Register supplying the amount; only the low byte is used |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry out |

## Verification
Two pairs of behaviour can meet in the same cycle.

The first pair is two moves that leave the operand unchanged: a zero amount, and a rotate by a nonzero multiple of 32. They must still disagree on the carry. The bench sends both with a carry flag opposite to operand bit 31. It then checks that one case returns the flag and the other returns the bit.

The second pair is reset and a live shift. Reset is raised while a shift that moves bits is on the inputs, and the bench requires both outputs to read zero after that edge.

// File: rtl/bshift_carry_pkg.sv
package bshift_carry_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

endpackage

// File: rtl/bsc_amount_sel.sv
module bsc_amount_sel #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int LW   = $clog2(W),
  localparam int IMM_W = LW + 1,
  localparam int CW   = LW + 1
) (
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  output logic [CW-1:0]    amt_clamp,
  output logic [LW-1:0]    amt_rot,
  output logic             amt_zero
);

  localparam logic [AMT_W-1:0] LIMIT = AMT_W'(W + 1);

  logic [AMT_W-1:0] eff;

  always_comb begin
    if (use_imm) eff = AMT_W'(imm_amt);
    else         eff = reg_amt;
    amt_zero = (eff == '0);
    amt_rot  = eff[LW-1:0];
    if (eff > LIMIT) amt_clamp = CW'(W + 1);
    else             amt_clamp = eff[CW-1:0];
  end

endmodule

// File: rtl/bsc_shift_core.sv
module bsc_shift_core
  import bshift_carry_pkg::*;
#(
  parameter int W   = 32,
  localparam int LW = $clog2(W),
  localparam int CW = LW + 1
) (
  input  logic [W-1:0]  x,
  input  logic [2:0]    kind,
  input  logic [CW-1:0] amt_clamp,
  input  logic [LW-1:0] amt_rot,
  input  logic          amt_zero,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);

  localparam logic [CW-1:0] FULL = CW'(W);

  logic          fill;
  logic [CW-1:0] rs;
  logic [2*W-1:0] rwide;
  logic [W:0]    rcar;
  logic [W:0]    lcar;
  logic [2*W-1:0] rot2;

  always_comb begin
    fill  = (kind == SK_ASR) ? x[W-1] : 1'b0;
    rs    = ((kind == SK_ASR) && (amt_clamp > FULL)) ? FULL : amt_clamp;
    rwide = {{W{fill}}, x} >> rs;
    rcar  = {x, cin} >> rs;
    lcar  = {cin, x} << amt_clamp;
    rot2  = {x, x} >> amt_rot;

    res  = x;
    cout = cin;
    case (kind)
      SK_LSL: if (!amt_zero) begin
        res  = x << amt_clamp;
        cout = lcar[W];
      end
      SK_LSR, SK_ASR: if (!amt_zero) begin
        res  = rwide[W-1:0];
        cout = rcar[0];
      end
      SK_ROR: if (!amt_zero) begin
        res  = rot2[W-1:0];
        cout = rot2[W-1];
      end
      SK_RRX: begin
        res  = {cin, x[W-1:1]};
        cout = x[0];
      end
      default: begin
        res  = x;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/bshift_carry.sv
module bshift_carry #(
  parameter int W      = 32,
  parameter int AMT_W  = 8,
  localparam int LW    = $clog2(W),
  localparam int IMM_W = LW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     op_i,
  input  logic [2:0]       kind_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [W-1:0]     reg_amt_i,
  input  logic             carry_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);

  localparam int CW = LW + 1;

  logic [CW-1:0] amt_clamp;
  logic [LW-1:0] amt_rot;
  logic          amt_zero;
  logic [W-1:0]  res_d;
  logic          carry_d;
  logic          unused_reg_hi;

  assign unused_reg_hi = ^reg_amt_i[W-1:AMT_W];

  bsc_amount_sel #(.W(W), .AMT_W(AMT_W)) u_amt (
    .use_imm   (use_imm_i),
    .imm_amt   (imm_amt_i),
    .reg_amt   (reg_amt_i[AMT_W-1:0]),
    .amt_clamp (amt_clamp),
    .amt_rot   (amt_rot),
    .amt_zero  (amt_zero)
  );

  bsc_shift_core #(.W(W)) u_core (
    .x         (op_i),
    .kind      (kind_i),
    .amt_clamp (amt_clamp),
    .amt_rot   (amt_rot),
    .amt_zero  (amt_zero),
    .cin       (carry_i),
    .res       (res_d),
    .cout      (carry_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      carry_o <= carry_d;
    end
  end

endmodule

// File: rtl/bshift_carry_chk.sv
module bshift_carry_chk #(
  parameter int W      = 32,
  parameter int AMT_W  = 8,
  localparam int LW    = $clog2(W),
  localparam int IMM_W = LW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     op_i,
  input logic [2:0]       kind_i,
  input logic             use_imm_i,
  input logic [IMM_W-1:0] imm_amt_i,
  input logic [W-1:0]     reg_amt_i,
  input logic             carry_i,
  input logic [W-1:0]     res_o,
  input logic             carry_o
);

  logic [AMT_W-1:0] n_eff;
  logic             unused_hi;

  assign unused_hi = ^reg_amt_i[W-1:AMT_W];
  assign n_eff = use_imm_i ? AMT_W'(imm_amt_i) : reg_amt_i[AMT_W-1:0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !carry_o);

  assert_zero_pass_R4: assert property (@(posedge clk) disable iff (rst)
    ((n_eff == '0) && (kind_i < 3'd4)) |=>
      (res_o == $past(op_i)) && (carry_o == $past(carry_i)));

  assert_reserved_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (kind_i > 3'd4) |=> (res_o == $past(op_i)) && (carry_o == $past(carry_i)));

  assert_lsr_over_R6: assert property (@(posedge clk) disable iff (rst)
    ((kind_i == 3'd1) && (n_eff > AMT_W'(W))) |=> (res_o == '0) && !carry_o);

  assert_asr_sat_R7: assert property (@(posedge clk) disable iff (rst)
    ((kind_i == 3'd2) && (n_eff >= AMT_W'(W))) |=>
      (res_o == {W{$past(op_i[W-1])}}) && (carry_o == $past(op_i[W-1])));

  assert_ror_pop_R8: assert property (@(posedge clk) disable iff (rst)
    ((kind_i == 3'd3) && (n_eff != '0)) |=>
      ($countones(res_o) == $countones($past(op_i))) && (carry_o == res_o[W-1]));

  assert_rrx_R9: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd4) |=>
      (res_o[W-1] == $past(carry_i)) && (res_o[W-2:0] == $past(op_i[W-1:1]))
      && (carry_o == $past(op_i[0])));

endmodule

bind bshift_carry bshift_carry_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .kind_i    (kind_i),
  .use_imm_i (use_imm_i),
  .imm_amt_i (imm_amt_i),
  .reg_amt_i (reg_amt_i),
  .carry_i   (carry_i),
  .res_o     (res_o),
  .carry_o   (carry_o)
);

// File: tb/tb_bshift_carry.sv
`timescale 1ns/1ps
module tb_bshift_carry;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_i = '0;
  logic [2:0]  kind_i = '0;
  logic        use_imm_i = 1'b0;
  logic [5:0]  imm_amt_i = '0;
  logic [31:0] reg_amt_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] res_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bshift_carry dut (
    .clk(clk), .rst(rst), .op_i(op_i), .kind_i(kind_i), .use_imm_i(use_imm_i),
    .imm_amt_i(imm_amt_i), .reg_amt_i(reg_amt_i), .carry_i(carry_i),
    .res_o(res_o), .carry_o(carry_o)
  );

  // fields: op[77:46] kind[45:43] imm[42] amt[41:34] cin[33] res[32:1] c[0]
  localparam int NV = 15;
  localparam logic [77:0] VEC [NV] = '{
    {32'h0000_00FF, 3'd0, 1'b1, 8'd4,   1'b0, 32'h0000_0FF0, 1'b0}, // R5
    {32'h8000_0001, 3'd0, 1'b1, 8'd1,   1'b0, 32'h0000_0002, 1'b1}, // R5
    {32'h8000_0000, 3'd1, 1'b1, 8'd32,  1'b0, 32'h0000_0000, 1'b1}, // R6
    {32'hF000_0000, 3'd1, 1'b1, 8'd4,   1'b1, 32'h0F00_0000, 1'b0}, // R6
    {32'h8000_0010, 3'd2, 1'b1, 8'd5,   1'b0, 32'hFC00_0000, 1'b1}, // R7
    {32'h7FFF_FFFF, 3'd2, 1'b0, 8'd200, 1'b1, 32'h0000_0000, 1'b0}, // R7
    {32'h0000_000F, 3'd3, 1'b1, 8'd4,   1'b0, 32'hF000_0000, 1'b1}, // R8
    {32'h1234_5678, 3'd3, 1'b0, 8'd64,  1'b1, 32'h1234_5678, 1'b0}, // R8
    {32'h1234_5678, 3'd3, 1'b0, 8'd8,   1'b0, 32'h7812_3456, 1'b0}, // R8
    {32'h0000_0001, 3'd4, 1'b1, 8'd17,  1'b1, 32'h8000_0000, 1'b1}, // R9
    {32'h0000_0001, 3'd0, 1'b0, 8'd32,  1'b0, 32'h0000_0000, 1'b1}, // R5
    {32'hFFFF_FFFF, 3'd0, 1'b0, 8'd33,  1'b1, 32'h0000_0000, 1'b0}, // R5
    {32'hDEAD_BEEF, 3'd1, 1'b0, 8'd0,   1'b1, 32'hDEAD_BEEF, 1'b1}, // R4
    {32'h0000_00F0, 3'd6, 1'b1, 8'd5,   1'b0, 32'h0000_00F0, 1'b0}, // R4
    {32'h8000_0000, 3'd2, 1'b0, 8'd32,  1'b0, 32'hFFFF_FFFF, 1'b1}  // R7
  };

  function automatic logic [32:0] ref_model(input logic [31:0] x, input logic [2:0] k,
                                            input int n, input logic ci);
    logic [31:0] r = x;
    logic        c = ci;
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      3'd3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      3'd4: begin c = r[0]; r = {ci, r[31:1]}; end
      default: ;
    endcase
    return {c, r};
  endfunction

  function automatic string req_of(input logic [2:0] k, input int n);
    if (k > 3'd4 || (k < 3'd4 && n == 0)) return "R4";
    case (k)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] er, input logic ec);
    checks++;
    if (res_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: res=%h carry=%b expected res=%h carry=%b", tag, res_o, carry_o, er, ec);
    end
  endtask

  task automatic drive(input logic [31:0] x, input logic [2:0] k, input logic imm,
                       input logic [5:0] ia, input logic [31:0] ra, input logic ci);
    @(negedge clk);
    op_i = x; kind_i = k; use_imm_i = imm; imm_amt_i = ia; reg_amt_i = ra; carry_i = ci;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    logic [32:0] e;
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h6DB6_DB6D, 32'hF0F0_1234};
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1 reset", 32'h0, 1'b0);
    rst = 1'b0;

    // table walk (register amounts carry junk in bits 31:8, R3)
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][77:46], VEC[v][45:43], VEC[v][42], VEC[v][39:34],
            {24'hA5A5A5, VEC[v][41:34]}, VEC[v][33]);
      compare(req_of(VEC[v][45:43], int'(VEC[v][41:34])), VEC[v][32:1], VEC[v][0]);
    end

    // R3: source select, upper register bits ignored
    drive(32'h0000_00F0, 3'd1, 1'b1, 6'd0, 32'h0000_0004, 1'b1);
    compare("R3 imm zero selected", 32'h0000_00F0, 1'b1);
    drive(32'h0000_00F0, 3'd1, 1'b0, 6'd4, 32'hFFFF_FF00, 1'b0);
    compare("R3 reg byte zero selected", 32'h0000_00F0, 1'b0);
    drive(32'h0000_00F0, 3'd1, 1'b0, 6'd0, 32'hABCD_EF04, 1'b1);
    compare("R3 reg low byte", 32'h0000_000F, 1'b0);

    // R4 vs R8: both unchanged, carry differs
    drive(32'h0123_4567, 3'd3, 1'b0, 6'd0, 32'd0, 1'b1);
    compare("R4 zero ror", 32'h0123_4567, 1'b1);
    drive(32'h0123_4567, 3'd3, 1'b0, 6'd0, 32'd96, 1'b1);
    compare("R8 ror multiple of 32", 32'h0123_4567, 1'b0);

    // R2: output holds until the next edge, then updates
    @(negedge clk);
    op_i = 32'h0000_0003; kind_i = 3'd0; use_imm_i = 1'b1; imm_amt_i = 6'd2; carry_i = 1'b0;
    #1 compare("R2 hold before edge", 32'h0123_4567, 1'b0);
    @(negedge clk);
    compare("R2 update after edge", 32'h0000_000C, 1'b0);

    // R1: reset wins over a live shift
    @(negedge clk);
    rst = 1'b1; op_i = 32'hFFFF_FFFF; kind_i = 3'd4; carry_i = 1'b1;
    @(negedge clk);
    compare("R1 reset during shift", 32'h0, 1'b0);
    rst = 1'b0;

    // sweep against the reference model
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 8; k++) begin
        for (int n = 0; n < 256; n++) begin
          drive(pats[p], 3'(k), 1'b0, 6'd0, {24'h5A5A5A, 8'(n)}, 1'(n ^ p));
          e = ref_model(pats[p], 3'(k), n, 1'(n ^ p));
          compare(req_of(3'(k), n), e[31:0], e[32]);
        end
        for (int n = 0; n < 64; n++) begin
          drive(pats[p], 3'(k), 1'b1, 6'(n), 32'hFFFF_FFFF, 1'(p));
          e = ref_model(pats[p], 3'(k), n, 1'(p));
          compare({req_of(3'(k), n), " R3 imm"}, e[31:0], e[32]);
        end
      end
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

endmodule